// File: doc/BRIEF.md
# Lockable Variable-Page Translation Buffer

This block is a small, fully associative address translation cache. It maps a 32-bit virtual address, tagged with an 8-bit address-space identifier, to a 32-bit physical address. Each entry carries its own page size, from 4 KB to 16 MB in steps of four. Page-number bits below the page boundary are left out of the tag compare and are copied from the virtual address into the physical address. The page offset always passes through unchanged.

The lookup path is purely combinational. The write port updates one entry on the next clock edge. The index comes either from the caller or from a round-robin victim pointer that steps over locked entries, so pinned mappings stay resident. When every entry is pinned, a victim write is refused and flagged. Lookups that match more than one entry raise an error flag and resolve to the lowest index. The top three virtual address bits are returned as a region code for the privilege classifier downstream.

Top module: `vpt_tlb`

## Requirements
- R1: After reset every entry is invalid and unlocked, every lookup misses, and the victim pointer is at entry 0, so `victim_idx` reads 0.
- R2: A lookup hits only when an entry is valid, its stored identifier equals `lk_asid`, and its stored page number equals `lk_va[31:12]` on every bit kept by that entry's page size. A lookup with any other identifier misses.
- R3: Size code c from 0 to 6 selects a page of 4 KB times 4 to the power c, and codes 7 and above behave as 16 MB. The low 12+2c address bits come from `lk_va`, and the bits above come from the entry's frame number.
- R4: `lk_region` always equals `lk_va[31:29]`.
- R5: When two or more entries match, `lk_multi` is 1 and the translation uses the lowest-indexed matching entry. Otherwise `lk_multi` is 0.
- R6: A write with `wr_use_victim`=1 targets the first unlocked entry found by searching upward, with wrap-around, from the pointer. `victim_idx` shows that entry. After the write, the pointer moves to the entry following it.
- R7: A locked entry is never chosen as the victim.
- R8: When every entry is locked, a victim write raises `replace_fail` in that same cycle and changes no entry.
- R9: A write with `wr_use_victim`=0 loads entry `wr_index` whether or not that entry is locked, and it leaves the victim pointer unchanged.
- R10: A lookup reflects only writes completed at earlier clock edges. A write becomes visible right after its edge.
- R11: A write with `wr_valid`=0 invalidates the target entry, so later lookups no longer hit it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_hit | output | 1 | Translation found |
| lk_multi | output | 1 | More than one entry matched |
| lk_pa | output | 32 | Physical address (meaningful on hit) |
| lk_region | output | 3 | Address-space region code, bits 31..29 |
| wr_en | input | 1 | Write an entry at the next edge |
| wr_use_victim | input | 1 | 1: victim pointer picks index, 0: use wr_index |
| wr_index | input | 4 | Explicit entry index |
| wr_valid | input | 1 | Valid bit to store |
| wr_lock | input | 1 | Lock bit to store |
| wr_asid | input | 8 | Identifier to store |
| wr_size | input | 3 | Page size code to store |
| wr_vpn | input | 20 | Virtual page number (address bits 31..12) |
| wr_pfn | input | 20 | Physical frame number (address bits 31..12) |
| victim_idx | output | 4 | Entry the next victim write would load |
| replace_fail | output | 1 | Victim write refused, all entries locked |

## Verification
The bench builds the block with its default of 16 entries. This entry count is small enough that a directed sequence of victim writes can lock the whole array and drive the all-locked refusal. With a pool of two identifiers, a handful of page numbers and every size code, random writes give frequent overlaps between large and small pages. That brings multi-hit resolution, masked compares and lock-skipping wrap-around of the pointer within reach many times over.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int ASID_W = 8;
  localparam int PN_W   = 20;
  localparam int OFF_W  = 12;
  localparam int SZ_W   = 3;
  localparam int SZ_MAX = 6;

  typedef logic [ASID_W-1:0] asid_t;
  typedef logic [PN_W-1:0]   pn_t;
  typedef logic [SZ_W-1:0]   sz_t;

  typedef struct packed {
    asid_t asid;
    pn_t   vpn;
    pn_t   pfn;
    sz_t   size;
  } tlb_data_t;

  // Page-number bits that take part in the compare for a given size code.
  function automatic pn_t size_mask(sz_t code);
    sz_t c;
    pn_t r;
    c = (code > sz_t'(SZ_MAX)) ? sz_t'(SZ_MAX) : code;
    r = '1;
    r = r << {c, 1'b0};
    return r;
  endfunction
endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int N = 16
) (
  input  pn_t                va_pn,
  input  asid_t              asid,
  input  logic [N-1:0]       valid,
  input  tlb_data_t [N-1:0]  ent,
  output logic [N-1:0]       match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    pn_t keep;
    assign keep     = size_mask(ent[g].size);
    assign match[g] = valid[g] && (ent[g].asid == asid) &&
                      (((va_pn ^ ent[g].vpn) & keep) == '0);
  end
endmodule

// File: rtl/vtlb_select.sv
module vtlb_select
  import vtlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]      match,
  input  tlb_data_t [N-1:0] ent,
  input  pn_t               va_pn,
  output logic              hit,
  output logic              multi,
  output pn_t               pa_pn
);
  logic [IDX_W-1:0] sel;
  logic [IDX_W:0]   cnt;
  pn_t              keep;

  always_comb begin
    sel = '0;
    cnt = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      cnt = cnt + {{IDX_W{1'b0}}, match[i]};
    end
    hit   = |match;
    multi = cnt > (IDX_W+1)'(1);
    keep  = size_mask(ent[sel].size);
    pa_pn = (ent[sel].pfn & keep) | (va_pn & ~keep);
  end
endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     locked,
  input  logic             advance,
  output logic [IDX_W-1:0] victim,
  output logic             all_locked
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] probe;
  logic             found;

  always_comb begin
    victim = ptr_q;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      probe = IDX_W'((int'(ptr_q) + k) % N);
      if (!found && !locked[probe]) begin
        victim = probe;
        found  = 1'b1;
      end
    end
    all_locked = &locked;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      ptr_d = (int'(victim) == N-1) ? '0 : victim + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vtlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_va,
  input  logic [7:0]        lk_asid,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic [31:0]       lk_pa,
  output logic [2:0]        lk_region,
  input  logic              wr_en,
  input  logic              wr_use_victim,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_valid,
  input  logic              wr_lock,
  input  logic [7:0]        wr_asid,
  input  logic [2:0]        wr_size,
  input  logic [19:0]       wr_vpn,
  input  logic [19:0]       wr_pfn,
  output logic [IDX_W-1:0]  victim_idx,
  output logic              replace_fail
);
  logic [N_ENTRIES-1:0]      valid_q, valid_d;
  logic [N_ENTRIES-1:0]      lock_q, lock_d;
  tlb_data_t [N_ENTRIES-1:0] ent_q;

  logic [N_ENTRIES-1:0] match;
  logic                 all_locked;
  logic                 do_wr, advance;
  logic [IDX_W-1:0]     wsel;
  pn_t                  pa_pn;
  tlb_data_t            wdata;

  // Lookup path
  vtlb_match #(.N(N_ENTRIES)) u_match (
    .va_pn (lk_va[31:OFF_W]),
    .asid  (lk_asid),
    .valid (valid_q),
    .ent   (ent_q),
    .match (match)
  );

  vtlb_select #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_select (
    .match (match),
    .ent   (ent_q),
    .va_pn (lk_va[31:OFF_W]),
    .hit   (lk_hit),
    .multi (lk_multi),
    .pa_pn (pa_pn)
  );

  assign lk_pa     = {pa_pn, lk_va[OFF_W-1:0]};
  assign lk_region = lk_va[31:29];

  // Replacement
  vtlb_victim #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (lock_q),
    .advance    (advance),
    .victim     (victim_idx),
    .all_locked (all_locked)
  );

  assign replace_fail = wr_en && wr_use_victim && all_locked;
  assign advance      = wr_en && wr_use_victim && !all_locked;
  assign do_wr        = wr_en && !replace_fail;
  assign wsel         = wr_use_victim ? victim_idx : wr_index;

  always_comb begin
    wdata.asid = wr_asid;
    wdata.vpn  = wr_vpn;
    wdata.pfn  = wr_pfn;
    wdata.size = wr_size;
  end

  // Next-state for flags
  always_comb begin
    valid_d = valid_q;
    lock_d  = lock_q;
    if (do_wr) begin
      valid_d[wsel] = wr_valid;
      lock_d[wsel]  = wr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
    end else if (do_wr) begin
      valid_q <= valid_d;
      lock_q  <= lock_d;
    end
  end

  // Entry payload: enable only, no reset
  always_ff @(posedge clk) begin
    if (do_wr) ent_q[wsel] <= wdata;
  end
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      lk_va,
  input logic [31:0]      lk_pa,
  input logic             lk_hit,
  input logic             lk_multi,
  input logic             wr_en,
  input logic             wr_use_victim,
  input logic             replace_fail,
  input logic [IDX_W-1:0] victim_idx,
  input logic [N-1:0]     valid_q,
  input logic [N-1:0]     lock_q
);
  a_r5_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

  a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_use_victim && !replace_fail) |-> !lock_q[victim_idx]);

  a_r8_fail_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    replace_fail |-> (&lock_q));

  a_r8_fail_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    replace_fail |=> ($stable(valid_q) && $stable(lock_q)));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(valid_q) && $stable(lock_q)));
endmodule

bind vpt_tlb vpt_tlb_chk #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_va         (lk_va),
  .lk_pa         (lk_pa),
  .lk_hit        (lk_hit),
  .lk_multi      (lk_multi),
  .wr_en         (wr_en),
  .wr_use_victim (wr_use_victim),
  .replace_fail  (replace_fail),
  .victim_idx    (victim_idx),
  .valid_q       (valid_q),
  .lock_q        (lock_q)
);

// File: tb/tb_vpt_tlb.sv
`timescale 1ns/1ps
module tb_vpt_tlb;
  localparam int N = 16;

  logic        clk, rst_n;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        lk_hit, lk_multi;
  logic [31:0] lk_pa;
  logic [2:0]  lk_region;
  logic        wr_en, wr_use_victim, wr_valid, wr_lock;
  logic [3:0]  wr_index;
  logic [7:0]  wr_asid;
  logic [2:0]  wr_size;
  logic [19:0] wr_vpn, wr_pfn;
  logic [3:0]  victim_idx;
  logic        replace_fail;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state
  bit          m_valid [N];
  bit          m_lock  [N];
  logic [7:0]  m_asid  [N];
  logic [19:0] m_vpn   [N];
  logic [19:0] m_pfn   [N];
  logic [2:0]  m_size  [N];
  int          m_ptr;

  vpt_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa), .lk_region(lk_region),
    .wr_en(wr_en), .wr_use_victim(wr_use_victim), .wr_index(wr_index),
    .wr_valid(wr_valid), .wr_lock(wr_lock), .wr_asid(wr_asid), .wr_size(wr_size),
    .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .victim_idx(victim_idx),
    .replace_fail(replace_fail)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [19:0] keep_bits(input logic [2:0] sz);
    int s;
    s = (sz >= 3'd6) ? 12 : 2 * int'(sz);
    return (20'hFFFFF >> s) << s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] a);
    int cnt, first;
    logic [19:0] k, ep;
    @(negedge clk);
    lk_va = va; lk_asid = a;
    #1;
    cnt = 0; first = -1;
    for (int i = 0; i < N; i++) begin
      k = keep_bits(m_size[i]);
      if (m_valid[i] && m_asid[i] == a && ((va[31:12] ^ m_vpn[i]) & k) == 20'h0) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    chk(lk_hit == (cnt > 0), "R2 hit", 32'(lk_hit), 32'(cnt > 0));
    chk(lk_multi == (cnt > 1), "R5 multi", 32'(lk_multi), 32'(cnt > 1));
    chk(lk_region == va[31:29], "R4 region", 32'(lk_region), 32'(va[31:29]));
    if (cnt > 0) begin
      k  = keep_bits(m_size[first]);
      ep = (m_pfn[first] & k) | (va[31:12] & ~k);
      chk(lk_pa == {ep, va[11:0]}, "R3 pa", lk_pa, {ep, va[11:0]});
    end
  endtask

  task automatic wr(input bit usev, input int idx, input logic [7:0] a,
                    input logic [19:0] vp, input logic [19:0] pf, input logic [2:0] sz,
                    input bit lk, input bit vl);
    int ev, tgt;
    bit al;
    @(negedge clk);
    wr_en = 1; wr_use_victim = usev; wr_index = 4'(idx); wr_asid = a;
    wr_vpn = vp; wr_pfn = pf; wr_size = sz; wr_lock = lk; wr_valid = vl;
    #1;
    al = 1; ev = -1;
    for (int i = 0; i < N; i++) if (!m_lock[i]) al = 0;
    for (int i = 0; i < N; i++) begin
      if (ev < 0 && !m_lock[(m_ptr + i) % N]) ev = (m_ptr + i) % N;
    end
    chk(replace_fail == (usev && al), "R8 replace_fail", 32'(replace_fail), 32'(usev && al));
    if (!al) chk(victim_idx == 4'(ev), "R6 R7 victim_idx", 32'(victim_idx), 32'(ev));
    @(posedge clk);
    if (!(usev && al)) begin
      tgt = usev ? ev : idx;
      m_valid[tgt] = vl; m_lock[tgt] = lk; m_asid[tgt] = a;
      m_vpn[tgt] = vp; m_pfn[tgt] = pf; m_size[tgt] = sz;
      if (usev) m_ptr = (ev + 1) % N;
    end
    #1 wr_en = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7041));
    rst_n = 0; wr_en = 0; wr_use_victim = 0; wr_index = 0; wr_valid = 0; wr_lock = 0;
    wr_asid = 0; wr_size = 0; wr_vpn = 0; wr_pfn = 0; lk_va = 0; lk_asid = 0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_lock[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_size[i] = 0;
    end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    #1;
    chk(victim_idx == 0, "R1 victim after reset", 32'(victim_idx), 0);
    chk(lk_hit == 0, "R1 miss after reset", 32'(lk_hit), 0);

    // R2/R10: 4 KB mapping, identifier mismatch
    wr(0, 3, 8'd5, 20'h12345, 20'hABCDE, 3'd0, 0, 1);
    lookup(32'h12345678, 8'd5);
    chk(lk_pa == 32'hABCDE678, "R10 visible after edge", lk_pa, 32'hABCDE678);
    lookup(32'h12345678, 8'd6);
    chk(lk_hit == 0, "R2 asid mismatch", 32'(lk_hit), 0);

    // R3: 16 MB via code 6 and code 7, 64 KB
    wr(0, 4, 8'd5, 20'hC0000, 20'h7F000, 3'd6, 0, 1);
    lookup(32'hC0123456, 8'd5);
    chk(lk_pa == 32'h7F123456, "R3 16MB", lk_pa, 32'h7F123456);
    wr(0, 5, 8'd5, 20'hA0000, 20'h11000, 3'd7, 0, 1);
    lookup(32'hA0FEDCBA, 8'd5);
    chk(lk_pa == 32'h11FEDCBA, "R3 code7", lk_pa, 32'h11FEDCBA);
    wr(0, 6, 8'd5, 20'h55550, 20'h22220, 3'd2, 0, 1);
    lookup(32'h5555ABCD, 8'd5);
    chk(lk_pa == 32'h2222ABCD, "R3 64KB", lk_pa, 32'h2222ABCD);
    lookup(32'h5556ABCD, 8'd5);
    chk(lk_hit == 0, "R3 64KB outside", 32'(lk_hit), 0);

    // R5: overlap of idx 3 and idx 8
    wr(0, 8, 8'd5, 20'h12340, 20'h99990, 3'd2, 0, 1);
    lookup(32'h12345678, 8'd5);
    chk(lk_multi == 1 && lk_pa == 32'hABCDE678, "R5 lowest wins", lk_pa, 32'hABCDE678);

    // R11: invalidate idx 3, idx 8 now serves
    wr(0, 3, 8'd5, 20'h12345, 20'hABCDE, 3'd0, 0, 0);
    lookup(32'h12345678, 8'd5);
    chk(lk_pa == 32'h99995678 && lk_multi == 0, "R11 invalidated", lk_pa, 32'h99995678);

    // R6/R7/R8: lock everything via victim writes, then overflow
    for (int i = 0; i < N; i++) wr(1, 0, 8'd9, 20'(i) << 8, 20'(i), 3'd0, 1, 1);
    wr(1, 0, 8'd9, 20'hEEEEE, 20'h1, 3'd0, 0, 1);
    lookup(32'hEEEEE000, 8'd9);
    chk(lk_hit == 0, "R8 nothing written", 32'(lk_hit), 0);

    // R9: explicit write overrides a lock, pointer unmoved
    wr(0, 2, 8'd9, 20'h33333, 20'h44444, 3'd0, 0, 1);
    lookup(32'h33333123, 8'd9);
    chk(lk_pa == 32'h44444123, "R9 explicit over lock", lk_pa, 32'h44444123);
    wr(1, 0, 8'd9, 20'h66666, 20'h77777, 3'd0, 0, 1);

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 4) begin
        logic [7:0] a;
        a = ($urandom % 2) ? 8'd5 : 8'd9;
        wr(bit'($urandom % 2), int'($urandom % N), a,
           {2'($urandom), 14'h0, 4'($urandom)}, 20'($urandom), 3'($urandom),
           ($urandom % 6) == 0, ($urandom % 8) != 0);
      end else begin
        logic [7:0] a;
        a = ($urandom % 2) ? 8'd5 : 8'd9;
        lookup({2'($urandom), 14'h0, 4'($urandom), 12'($urandom)}, a);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule